// File: doc/BRIEF.md
# Interrupt Event Register Set

This block is the interrupt and event register set at the edge of a peripheral. Up to 32 raw event lines come in from the peripheral's logic. A single line goes out toward the event fabric or interrupt controller. Each incoming pulse is latched into a raw status word. A software-written enable word gates the raw status into a masked status, and the output line is high whenever any masked bit is pending.

Software reaches the block through a simple word-addressed register bus. Read data is combinational for the address presented, and writes take effect at the clock edge. Software can force status bits on or off through dedicated set and clear registers. It can also read a pending-index register, which reports the highest-priority masked source. That same read retires the source it reports, so one access both identifies and acknowledges the event.

Top module: `evt_irq_regs`

## Requirements
- R1: After reset the raw status, enable word and masked status read 0, the pending index reads 0 and `irq_o` is low.
- R2: Writing the SET register (word address 3) sets every raw status bit whose data bit is 1 and leaves bits written 0 unchanged; SET always reads back 0.
- R3: Writing the CLR register (word address 4) clears every raw status bit whose data bit is 1 and leaves the others unchanged; CLR always reads back 0.
- R4: The masked status (word address 2) reads as raw status (address 0) AND enable (address 1); writes to the masked status or raw status addresses change nothing.
- R5: `irq_o` is high while any masked status bit is set, and it is low in the cycle after the last masked bit is cleared if no new event arrives.
- R6: A read of the pending index (word address 5) returns 0 when no masked bit is set; otherwise it returns the lowest set masked bit number plus 1 (bit 0 has the highest priority).
- R7: A pending-index read that returns a nonzero value clears that source's raw status bit at the same clock edge, and so its masked bit too.
- R8: A pending-index read that returns 0 leaves all status unchanged, and a write to the pending-index address has no effect.
- R9: A one-cycle pulse on `src_evt_i[k]` sets raw bit k; when that set meets a CLR write or a pending-index clear of the same bit in the same cycle, the bit ends up set.
- R10: Raw bits whose enable bit is 0 do not raise `irq_o` and are not reported by the pending index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Register access valid this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the presented address |
| src_evt_i | input | NUM_SRC | Hardware event pulses, one per source |
| irq_o | output | 1 | Event or interrupt request toward the fabric |

## Verification
The pending-index read is tried with a single masked bit, two masked bits of different priority, bits at both ends of the word, and pending bits that are all disabled. These patterns separate a correct lowest-bit-first encoder from one that picks the highest bit, reads raw instead of masked status, or is off by one in the code. Status changes are tried through SET, CLR, index reads and hardware pulses, including a pulse that lands in the same cycle as a software clear or an index clear, which tells apart a design where the hardware set wins from one where the clear wins. The output line is sampled in the cycle right after the last clear, to catch a design that drops it one cycle late.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  localparam int BUS_DW = 32;
  localparam int BUS_AW = 3;
  localparam int CODE_W = 6;

  typedef enum logic [BUS_AW-1:0] {
    REG_RAW  = 3'd0,
    REG_ENA  = 3'd1,
    REG_MSKD = 3'd2,
    REG_SET  = 3'd3,
    REG_CLR  = 3'd4,
    REG_IDX  = 3'd5
  } reg_sel_e;

  // One-hot vector to index code: 0 for none, bit number + 1 otherwise.
  function automatic logic [CODE_W-1:0] onehot_code(input logic [BUS_DW-1:0] oh);
    logic [CODE_W-1:0] code;
    code = '0;
    for (int i = 0; i < BUS_DW; i++) begin
      if (oh[i]) code = code | CODE_W'(i + 1);
    end
    return code;
  endfunction

  // Next raw status: clears first, then software and hardware sets on top.
  function automatic logic [BUS_DW-1:0] raw_next(
    input logic [BUS_DW-1:0] cur,
    input logic [BUS_DW-1:0] sets,
    input logic [BUS_DW-1:0] clrs
  );
    return (cur & ~clrs) | sets;
  endfunction

endpackage

// File: rtl/evt_bus_decode.sv
module evt_bus_decode
  import evt_irq_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [BUS_AW-1:0]  bus_addr,
  input  logic [BUS_DW-1:0]  bus_wdata,
  output logic [NUM_SRC-1:0] sw_set,
  output logic [NUM_SRC-1:0] sw_clr,
  output logic               ena_we,
  output logic               idx_rd
);

  logic wr_hit_set;
  logic wr_hit_clr;

  assign wr_hit_set = bus_en && bus_we && (bus_addr == REG_SET);
  assign wr_hit_clr = bus_en && bus_we && (bus_addr == REG_CLR);
  assign ena_we     = bus_en && bus_we && (bus_addr == REG_ENA);
  assign idx_rd     = bus_en && !bus_we && (bus_addr == REG_IDX);

  assign sw_set = wr_hit_set ? bus_wdata[NUM_SRC-1:0] : '0;
  assign sw_clr = wr_hit_clr ? bus_wdata[NUM_SRC-1:0] : '0;

endmodule

// File: rtl/evt_prio_pick.sv
module evt_prio_pick
  import evt_irq_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic [NUM_SRC-1:0] pend,
  output logic [NUM_SRC-1:0] pick_oh,
  output logic [CODE_W-1:0]  pick_code
);

  logic [NUM_SRC:0]  below_any;
  logic [BUS_DW-1:0] oh_wide;

  assign below_any[0] = 1'b0;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
    assign below_any[g+1] = below_any[g] | pend[g];
    assign pick_oh[g]     = pend[g] & ~below_any[g];
  end

  always_comb begin
    oh_wide = '0;
    oh_wide[NUM_SRC-1:0] = pick_oh;
  end

  assign pick_code = onehot_code(oh_wide);

endmodule

// File: rtl/evt_status_regs.sv
module evt_status_regs
  import evt_irq_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] sw_set,
  input  logic [NUM_SRC-1:0] sw_clr,
  input  logic [NUM_SRC-1:0] idx_clr,
  input  logic [NUM_SRC-1:0] hw_evt,
  input  logic               ena_we,
  input  logic [NUM_SRC-1:0] ena_wdata,
  output logic [NUM_SRC-1:0] raw_q,
  output logic [NUM_SRC-1:0] ena_q
);

  logic [BUS_DW-1:0] cur_w, set_w, clr_w, nxt_w;

  always_comb begin
    cur_w = '0;
    set_w = '0;
    clr_w = '0;
    cur_w[NUM_SRC-1:0] = raw_q;
    set_w[NUM_SRC-1:0] = sw_set | hw_evt;
    clr_w[NUM_SRC-1:0] = sw_clr | idx_clr;
    nxt_w = raw_next(cur_w, set_w, clr_w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
    end else begin
      raw_q <= nxt_w[NUM_SRC-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q <= '0;
    end else if (ena_we) begin
      ena_q <= ena_wdata;
    end
  end

endmodule

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
  import evt_irq_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [BUS_AW-1:0]  bus_addr,
  input  logic [BUS_DW-1:0]  bus_wdata,
  output logic [BUS_DW-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] src_evt_i,
  output logic               irq_o
);

  logic [NUM_SRC-1:0] sw_set, sw_clr, idx_clr;
  logic [NUM_SRC-1:0] raw_q, ena_q, mskd;
  logic [NUM_SRC-1:0] pick_oh;
  logic [CODE_W-1:0]  pick_code;
  logic               ena_we, idx_rd;

  evt_bus_decode #(.NUM_SRC(NUM_SRC)) u_dec (
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .sw_set    (sw_set),
    .sw_clr    (sw_clr),
    .ena_we    (ena_we),
    .idx_rd    (idx_rd)
  );

  evt_status_regs #(.NUM_SRC(NUM_SRC)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_set    (sw_set),
    .sw_clr    (sw_clr),
    .idx_clr   (idx_clr),
    .hw_evt    (src_evt_i),
    .ena_we    (ena_we),
    .ena_wdata (bus_wdata[NUM_SRC-1:0]),
    .raw_q     (raw_q),
    .ena_q     (ena_q)
  );

  assign mskd = raw_q & ena_q;

  evt_prio_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .pend      (mskd),
    .pick_oh   (pick_oh),
    .pick_code (pick_code)
  );

  // The reported source is retired by the same read that reports it.
  assign idx_clr = idx_rd ? pick_oh : '0;
  assign irq_o   = |mskd;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      REG_RAW:  bus_rdata[NUM_SRC-1:0] = raw_q;
      REG_ENA:  bus_rdata[NUM_SRC-1:0] = ena_q;
      REG_MSKD: bus_rdata[NUM_SRC-1:0] = mskd;
      REG_IDX:  bus_rdata[CODE_W-1:0]  = pick_code;
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/evt_irq_regs_chk.sv
module evt_irq_regs_chk
  import evt_irq_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               idx_rd,
  input logic [NUM_SRC-1:0] pick_oh,
  input logic [CODE_W-1:0]  pick_code,
  input logic [NUM_SRC-1:0] hw_evt,
  input logic [NUM_SRC-1:0] raw_q,
  input logic [NUM_SRC-1:0] ena_q,
  input logic               irq_o
);

  // R5: output line tracks any enabled pending bit
  a_r5_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == |(raw_q & ena_q));

  // R6: at most one source is picked, and one is picked whenever any is enabled and pending
  a_r6_pick_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_oh) && ((pick_oh != '0) == (|(raw_q & ena_q))));

  // R6: code is zero exactly when nothing is picked
  a_r6_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_code == '0) == (pick_oh == '0));

  // R7: a reporting index read retires the reported bit unless hardware sets it again
  a_r7_idx_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_rd && (pick_oh != '0)) |=> ((raw_q & $past(pick_oh) & ~$past(hw_evt)) == '0));

  // R8: an empty index read leaves raw status alone when no hardware event arrives
  a_r8_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_rd && (pick_oh == '0) && (hw_evt == '0)) |=> (raw_q == $past(raw_q)));

  // R9: every hardware pulse lands in raw status
  a_r9_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_evt != '0) |=> ((raw_q & $past(hw_evt)) == $past(hw_evt)));

endmodule

bind evt_irq_regs evt_irq_regs_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .idx_rd    (idx_rd),
  .pick_oh   (pick_oh),
  .pick_code (pick_code),
  .hw_evt    (src_evt_i),
  .raw_q     (raw_q),
  .ena_q     (ena_q),
  .irq_o     (irq_o)
);

// File: tb/tb_evt_irq_regs.sv
module tb_evt_irq_regs;

  localparam int NUM_SRC = 32;
  localparam logic [2:0] A_RAW = 3'd0, A_ENA = 3'd1, A_MSKD = 3'd2,
                         A_SET = 3'd3, A_CLR = 3'd4, A_IDX = 3'd5;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_en, bus_we;
  logic [2:0]        bus_addr;
  logic [31:0]       bus_wdata, bus_rdata;
  logic [NUM_SRC-1:0] src_evt_i;
  logic              irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  evt_irq_regs #(.NUM_SRC(NUM_SRC)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_evt_i (src_evt_i),
    .irq_o     (irq_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got 0x%08h expected 0x%08h", req, what, got, exp);
    end
  endtask

  // One bus cycle started at a falling edge; read data sampled before the rising edge.
  task automatic access(input logic we, input logic [2:0] a, input logic [31:0] wd,
                        input logic [NUM_SRC-1:0] hw, output logic [31:0] rd);
    bus_en = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd; src_evt_i = hw;
    #1 rd = bus_rdata;
    @(posedge clk);
    #1;
    bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0; src_evt_i = '0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    logic [31:0] unused;
    access(1'b1, a, d, '0, unused);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    access(1'b0, a, '0, '0, d);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1", "irq after reset", {31'd0, irq_o}, 32'd0);
    rd(A_RAW, v);  chk("R1", "raw after reset", v, 32'd0);
    rd(A_ENA, v);  chk("R1", "enable after reset", v, 32'd0);
    rd(A_MSKD, v); chk("R1", "masked after reset", v, 32'd0);
    rd(A_IDX, v);  chk("R1", "index after reset", v, 32'd0);
  endtask

  task automatic t_set_clr;
    logic [31:0] v;
    wr(A_SET, 32'h0000_00A5);
    rd(A_RAW, v); chk("R2", "raw after SET", v, 32'h0000_00A5);
    rd(A_SET, v); chk("R2", "SET reads zero", v, 32'd0);
    wr(A_SET, 32'd0);
    rd(A_RAW, v); chk("R2", "SET of zeros", v, 32'h0000_00A5);
    rd(A_CLR, v); chk("R3", "CLR reads zero", v, 32'd0);
    wr(A_CLR, 32'h0000_0005);
    rd(A_RAW, v); chk("R3", "raw after CLR", v, 32'h0000_00A0);
    wr(A_CLR, 32'd0);
    rd(A_RAW, v); chk("R3", "CLR of zeros", v, 32'h0000_00A0);
  endtask

  task automatic t_mask_index;
    logic [31:0] v;
    wr(A_ENA, 32'h0000_000F);
    rd(A_MSKD, v); chk("R4", "masked with disjoint enable", v, 32'd0);
    chk("R10", "irq with only disabled bits", {31'd0, irq_o}, 32'd0);
    rd(A_IDX, v);  chk("R10", "index ignores disabled bits", v, 32'd0);
    rd(A_RAW, v);  chk("R8", "raw after empty index read", v, 32'h0000_00A0);
    wr(A_MSKD, 32'hFFFF_FFFF);
    wr(A_RAW, 32'd0);
    rd(A_RAW, v);  chk("R4", "raw after writes to read-only words", v, 32'h0000_00A0);
    rd(A_MSKD, v); chk("R4", "masked after write attempt", v, 32'd0);
    wr(A_ENA, 32'h0000_00F0);
    rd(A_MSKD, v); chk("R4", "masked equals raw and enable", v, 32'h0000_00A0);
    chk("R5", "irq with enabled pending", {31'd0, irq_o}, 32'd1);
    rd(A_IDX, v);  chk("R6", "index of bit 5", v, 32'd6);
    rd(A_RAW, v);  chk("R7", "bit 5 retired", v, 32'h0000_0080);
    rd(A_IDX, v);  chk("R6", "index of bit 7", v, 32'd8);
    chk("R5", "irq drops right after last clear", {31'd0, irq_o}, 32'd0);
    rd(A_RAW, v);  chk("R7", "bit 7 retired", v, 32'd0);
    wr(A_SET, 32'h0000_0002);
    wr(A_IDX, 32'hFFFF_FFFF);
    rd(A_RAW, v);  chk("R8", "write to index has no effect", v, 32'h0000_0002);
    wr(A_SET, 32'h0000_0010);
    chk("R5", "irq raised by SET", {31'd0, irq_o}, 32'd1);
    wr(A_CLR, 32'h0000_0010);
    chk("R5", "irq drops right after CLR", {31'd0, irq_o}, 32'd0);
  endtask

  task automatic t_hw;
    logic [31:0] v;
    wr(A_ENA, 32'h0000_0008);
    access(1'b0, A_RAW, '0, 32'h0000_0008, v);
    rd(A_RAW, v); chk("R9", "hardware pulse sets bit 3", v, 32'h0000_000A);
    chk("R5", "irq from hardware event", {31'd0, irq_o}, 32'd1);
    access(1'b1, A_CLR, 32'h0000_0008, 32'h0000_0008, v);
    rd(A_RAW, v); chk("R9", "hardware set beats CLR", v, 32'h0000_000A);
    access(1'b0, A_IDX, '0, 32'h0000_0008, v);
    chk("R6", "index with simultaneous event", v, 32'd4);
    rd(A_RAW, v); chk("R9", "hardware set beats index clear", v, 32'h0000_000A);
  endtask

  task automatic t_edges;
    logic [31:0] v;
    wr(A_CLR, 32'hFFFF_FFFF);
    wr(A_ENA, 32'hFFFF_FFFF);
    wr(A_SET, 32'h8000_0001);
    rd(A_IDX, v); chk("R6", "bit 0 wins over bit 31", v, 32'd1);
    rd(A_IDX, v); chk("R6", "index of bit 31", v, 32'd32);
    rd(A_IDX, v); chk("R6", "index when empty", v, 32'd0);
    rd(A_RAW, v); chk("R7", "both ends retired", v, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0;
    bus_wdata = '0; src_evt_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_clr();
    t_mask_index();
    t_hw();
    t_edges();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule